// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Sized Reads

This block is a small direct-mapped data cache. It has eight lines, and each line holds four 32-bit words, one tag and one valid bit. The CPU presents one request per cycle: an address, a read or write strobe, write data and a read-size code. The address carries the byte offset, the word index, the line index and the tag. One cycle after the request, the cache gives a hit flag and a read value. That value is a right-aligned slice of one to four bytes of the selected word.

A write stores one full word into the line picked by the address and marks that line valid. If the line held another tag, or was not yet valid, the write claims it: the new tag goes in, the other three words are cleared, and the new word is written in place. A write to a line that already holds the same tag changes only the addressed word. The cache does not refill from memory and keeps no coherence state.

Top module: `dm_cache_top`

## Requirements
- R1: Reset clears every valid bit, so any read issued after reset reports a miss with zero data until a write fills the line.
- R2: A request issued in cycle k gives its result in cycle k+1. That result is a hit only when the addressed line is valid and its stored tag equals the request tag.
- R3: Address fields are laid out as follows: bits [1:0] are the byte offset, bits [4:2] the word index, bits [7:5] the line index (value n selects line n) and bits [33:8] the tag. Lines with different indices are independent.
- R4: The read-size code picks how many bytes come back: 2'b00 gives 1 byte, 2'b01 gives 2, 2'b10 gives 3 and 2'b11 gives 4. The bytes are right-aligned and every byte above the requested count reads as zero.
- R5: The returned slice begins at the byte given by the byte offset. Bytes that would lie beyond bit 31 of the word read as zero.
- R6: A word index of 4 to 7 always reports a miss with zero data. A write with such an index changes no stored state.
- R7: A write to a line that is invalid or holds a different tag installs the new tag, sets the valid bit, zeroes the line's other words and stores the write data in the addressed word.
- R8: A write to a valid line with a matching tag updates only the addressed word and leaves the other words unchanged.
- R9: A miss, or a cycle with no request, reports hit low and zero data. A write request reports the lookup made before the write is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 34 | Byte address: tag, line index, word index, byte offset |
| req_wdata | input | 32 | Word to store on a write |
| req_size | input | 2 | Read-size code, 1 to 4 bytes |
| rsp_hit | output | 1 | Lookup result for the previous cycle's request |
| rsp_data | output | 32 | Right-aligned, zero-filled read slice |

## Verification
Every result, hit flag and data slice alike, is registered once. It therefore belongs to the request driven in the cycle before. Writes land at the same edge, so they are seen by the request that follows. The bench drives each request on a falling edge and samples one time unit after the next rising edge. At that point it compares the outputs with a bench-side line model, whose state is taken from before that request's write is applied. Directed cases pin literal values for every size code, for every offset that crosses the word boundary, for illegal word indices, for tag replacement and for partial-line updates. Seeded random traffic then runs over a small pool of tags.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 2;
    localparam int WSEL_W = 3;
    localparam int IDX_LSB = OFF_W + WSEL_W;

    typedef enum logic [1:0] {
        SZ_1B = 2'b00,
        SZ_2B = 2'b01,
        SZ_3B = 2'b10,
        SZ_4B = 2'b11
    } rd_size_e;

endpackage

// File: rtl/dm_cache_lookup.sv
module dm_cache_lookup #(
    parameter int TAG_W  = 26,
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int SET_W  = $clog2(SETS),
    parameter int WIDX_W = $clog2(WORDS)
) (
    input  logic [SETS-1:0]                          valid,
    input  logic [SETS-1:0][TAG_W-1:0]               tags,
    input  logic [SETS-1:0][WORDS-1:0][DATA_W-1:0]   lines,
    input  logic [SET_W-1:0]                         set_idx,
    input  logic [dm_cache_pkg::WSEL_W-1:0]          word_sel,
    input  logic [TAG_W-1:0]                         tag,
    output logic                                     line_match,
    output logic                                     word_ok,
    output logic                                     hit,
    output logic [DATA_W-1:0]                        word
);

    always_comb begin
        line_match = valid[set_idx] && (tags[set_idx] == tag);
        word_ok    = (int'(word_sel) < WORDS);
        hit        = line_match && word_ok;
        word       = hit ? lines[set_idx][word_sel[WIDX_W-1:0]] : '0;
    end

    always_comb begin
        if (hit) begin
            AST_HIT_NEEDS_VALID: assert (valid[set_idx] && word_sel < 3'(WORDS)); // R2
        end
    end

endmodule

// File: rtl/dm_cache_align.sv
module dm_cache_align #(
    parameter int DATA_W = 32,
    parameter int NBYTES = DATA_W / dm_cache_pkg::BYTE_W
) (
    input  logic [DATA_W-1:0]               word,
    input  logic [dm_cache_pkg::OFF_W-1:0]  byte_off,
    input  dm_cache_pkg::rd_size_e          size,
    output logic [DATA_W-1:0]               slice
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = word >> (int'(byte_off) * dm_cache_pkg::BYTE_W);
        for (int b = 0; b < NBYTES; b++) begin
            slice[b*dm_cache_pkg::BYTE_W +: dm_cache_pkg::BYTE_W] =
                (b <= int'(size)) ? shifted[b*dm_cache_pkg::BYTE_W +: dm_cache_pkg::BYTE_W]
                                  : '0;
        end
    end

endmodule

// File: rtl/dm_cache_top.sv
module dm_cache_top #(
    parameter int ADDR_W = 34,
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_size,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);

    import dm_cache_pkg::*;

    localparam int SET_W  = $clog2(SETS);
    localparam int WIDX_W = $clog2(WORDS);
    localparam int TAG_W  = ADDR_W - IDX_LSB - SET_W;

    typedef struct packed {
        logic [SETS-1:0]                        valid;
        logic [SETS-1:0][TAG_W-1:0]             tags;
        logic [SETS-1:0][WORDS-1:0][DATA_W-1:0] lines;
        logic                                   hit;
        logic [DATA_W-1:0]                      data;
    } state_t;

    state_t st_d, st_q;

    logic [OFF_W-1:0]  off_w;
    logic [WSEL_W-1:0] wsel_w;
    logic [SET_W-1:0]  set_w;
    logic [TAG_W-1:0]  tag_w;
    logic              match_w, word_ok_w, hit_w;
    logic [DATA_W-1:0] word_w, slice_w;

    assign off_w  = req_addr[OFF_W-1:0];
    assign wsel_w = req_addr[OFF_W +: WSEL_W];
    assign set_w  = req_addr[IDX_LSB +: SET_W];
    assign tag_w  = req_addr[ADDR_W-1 -: TAG_W];

    dm_cache_lookup #(
        .TAG_W (TAG_W),
        .SETS  (SETS),
        .WORDS (WORDS),
        .DATA_W(DATA_W)
    ) lookup_i (
        .valid     (st_q.valid),
        .tags      (st_q.tags),
        .lines     (st_q.lines),
        .set_idx   (set_w),
        .word_sel  (wsel_w),
        .tag       (tag_w),
        .line_match(match_w),
        .word_ok   (word_ok_w),
        .hit       (hit_w),
        .word      (word_w)
    );

    dm_cache_align #(
        .DATA_W(DATA_W)
    ) align_i (
        .word    (word_w),
        .byte_off(off_w),
        .size    (rd_size_e'(req_size)),
        .slice   (slice_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hit  = req_valid && hit_w;
        st_d.data = (req_valid && hit_w) ? slice_w : '0;
        if (req_valid && req_write && word_ok_w) begin
            if (!match_w) begin
                st_d.lines[set_w] = '0;
                st_d.tags[set_w]  = tag_w;
                st_d.valid[set_w] = 1'b1;
            end
            st_d.lines[set_w][wsel_w[WIDX_W-1:0]] = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_hit  = st_q.hit;
    assign rsp_data = st_q.data;

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_data == '0); // R9
    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_hit); // R9
    AST_BAD_WORD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_addr[OFF_W+WSEL_W-1] |=> !rsp_hit); // R6
    AST_ONE_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_size == 2'b00 |=> rsp_data[DATA_W-1:BYTE_W] == '0); // R4
    AST_TOP_OFFSET_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_addr[OFF_W-1:0] == 2'b11 |=> rsp_data[DATA_W-1:BYTE_W] == '0); // R5

endmodule

// File: tb/dm_cache_top_tb_top.sv
`timescale 1ns/1ps
module dm_cache_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [33:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        rsp_hit;
    logic [31:0] rsp_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [25:0] m_tag [8];
    bit          m_val [8];
    logic [31:0] m_dat [8][4];

    always #2 clk = ~clk;

    dm_cache_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_size (req_size),
        .rsp_hit  (rsp_hit),
        .rsp_data (rsp_data)
    );

    function automatic logic [31:0] slice_of(logic [31:0] w, int off, int sz);
        logic [31:0] s;
        logic [31:0] r;
        s = w >> (off * 8);
        r = '0;
        for (int b = 0; b <= sz; b++) r[b*8 +: 8] = s[b*8 +: 8];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(bit wr, logic [25:0] tag, int set, int widx, int off, int sz,
                      logic [31:0] wd, string req,
                      bit lit = 1'b0, bit lhit = 1'b0, logic [31:0] ldat = '0);
        bit          eh;
        logic [31:0] ed;
        eh = m_val[set] && m_tag[set] == tag && widx < 4;
        ed = eh ? slice_of(m_dat[set][widx[1:0]], off, sz) : 32'h0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {tag, 3'(set), 3'(widx), 2'(off)};
        req_wdata = wd;
        req_size  = 2'(sz);
        @(posedge clk);
        #1;
        check({req, " hit"}, {31'b0, rsp_hit}, {31'b0, eh});
        check({req, " data"}, rsp_data, ed);
        if (lit) begin
            check({req, " hit literal"}, {31'b0, rsp_hit}, {31'b0, lhit});
            check({req, " data literal"}, rsp_data, ldat);
        end
        if (wr && widx < 4) begin
            if (!(m_val[set] && m_tag[set] == tag)) begin
                for (int i = 0; i < 4; i++) m_dat[set][i] = '0;
                m_tag[set] = tag;
                m_val[set] = 1'b1;
            end
            m_dat[set][widx[1:0]] = wd;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    localparam logic [25:0] TA = 26'h2AA_5555;
    localparam logic [25:0] TB = 26'h155_AAAA;
    localparam logic [25:0] TC = 26'h000_0001;

    initial begin
        for (int s = 0; s < 8; s++) begin
            m_val[s] = 1'b0;
            m_tag[s] = '0;
            for (int i = 0; i < 4; i++) m_dat[s][i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset hit", {31'b0, rsp_hit}, 32'h0);
        check("R1 reset data", rsp_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        op(0, TA, 0, 0, 0, 3, 0, "R1 read after reset", 1, 0, 32'h0);
        op(1, TA, 0, 0, 0, 3, 32'h1122_3344, "R7 fill write", 1, 0, 32'h0);
        op(0, TA, 0, 0, 0, 3, 0, "R2 full word hit", 1, 1, 32'h1122_3344);
        op(0, TA, 0, 0, 0, 0, 0, "R4 size 1 byte", 1, 1, 32'h0000_0044);
        op(0, TA, 0, 0, 0, 1, 0, "R4 size 2 bytes", 1, 1, 32'h0000_3344);
        op(0, TA, 0, 0, 0, 2, 0, "R4 size 3 bytes", 1, 1, 32'h0022_3344);
        op(0, TA, 0, 0, 2, 3, 0, "R5 offset 2 crossing", 1, 1, 32'h0000_1122);
        op(0, TA, 0, 0, 3, 1, 0, "R5 offset 3 crossing", 1, 1, 32'h0000_0011);
        op(0, TA, 0, 0, 1, 1, 0, "R5 offset 1 inside", 1, 1, 32'h0000_2233);
        op(0, TB, 0, 0, 0, 3, 0, "R2 tag mismatch", 1, 0, 32'h0);
        op(0, TA, 0, 5, 0, 3, 0, "R6 word index 5", 1, 0, 32'h0);
        op(1, TA, 1, 6, 0, 3, 32'hDEAD_BEEF, "R6 illegal write", 1, 0, 32'h0);
        op(0, TA, 1, 0, 0, 3, 0, "R6 illegal write ignored", 1, 0, 32'h0);
        op(1, TA, 0, 1, 0, 3, 32'hCAFE_F00D, "R9 write reports lookup", 1, 1, 32'h0);
        op(0, TA, 0, 0, 0, 3, 0, "R8 other word kept", 1, 1, 32'h1122_3344);
        op(0, TA, 0, 1, 0, 3, 0, "R8 updated word", 1, 1, 32'hCAFE_F00D);
        op(1, TB, 0, 2, 0, 3, 32'h5A5A_0F0F, "R7 replace write", 1, 0, 32'h0);
        op(0, TA, 0, 0, 0, 3, 0, "R7 old tag gone", 1, 0, 32'h0);
        op(0, TB, 0, 0, 0, 3, 0, "R7 other word cleared", 1, 1, 32'h0);
        op(0, TB, 0, 2, 0, 3, 0, "R7 new word", 1, 1, 32'h5A5A_0F0F);
        op(1, TA, 7, 3, 0, 3, 32'h8765_4321, "R3 write line 7", 1, 0, 32'h0);
        op(0, TA, 7, 3, 0, 3, 0, "R3 line 7 hit", 1, 1, 32'h8765_4321);
        op(0, TB, 0, 2, 0, 3, 0, "R3 line 0 intact", 1, 1, 32'h5A5A_0F0F);
        op(0, TA, 6, 3, 0, 3, 0, "R3 line 6 empty", 1, 0, 32'h0);

        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = {TB, 3'd0, 3'd2, 2'd0};
        @(posedge clk);
        #1;
        check("R9 idle hit", {31'b0, rsp_hit}, 32'h0);
        check("R9 idle data", rsp_data, 32'h0);

        void'($urandom(32'd1234));
        for (int k = 0; k < 3000; k++) begin
            logic [25:0] t;
            int pick;
            pick = int'($urandom_range(0, 2));
            t = (pick == 0) ? TA : (pick == 1) ? TB : TC;
            op(($urandom_range(0, 2) == 0), t, int'($urandom_range(0, 7)),
               ($urandom_range(0, 7) == 0) ? int'($urandom_range(4, 7)) : int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), $urandom,
               "R2 R4 R5 R7 R8 random");
        end

        @(negedge clk);
        req_valid = 1'b0;
        finish_run();
    end

endmodule